// File: doc/BRIEF.md
# Condition-Flag Data Processing ALU

This block is the data processing stage of a load/store RISC core. On each accepted cycle it takes a 4-bit operation code, a first operand, and a second operand. The second operand is either a register value or an 8-bit constant rotated right inside a 32-bit word. It computes one of sixteen arithmetic or logical results. The result and a destination write-enable are registered and appear one clock later. The block also keeps a four-bit condition flag register holding negative, zero, carry and overflow.

The flag register changes only in two cases: the set-flags control is high, or the operation is one of the four test/compare codes. The test/compare codes update the flags and never write the destination. The carry-chained forms read the carry bit of the flag register as it stands before the operation. A stream of chained operations therefore behaves like a multi-word add or subtract.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, `result` is 0, `rd_we` is 0 and `flags` is 0.
- R2: With `imm_sel`=0 the second operand is `opb_reg`. With `imm_sel`=1 it is `imm_field[7:0]` zero-extended to 32 bits and rotated right by twice `imm_field[11:8]`.
- R3: Arithmetic codes, where a is the first operand, b the second and c the flag-register carry: 0010 gives a-b, 0011 gives b-a, 0100 gives a+b, 0101 gives a+b+c, 0110 gives a-b-1+c, 0111 gives b-a-1+c.
- R4: Logical codes: 0000 gives a AND b, 0001 gives a XOR b, 1100 gives a OR b, 1101 gives b, 1110 gives a AND NOT b, 1111 gives NOT b.
- R5: Test/compare codes are 1000 (AND), 1001 (XOR), 1010 (a-b) and 1011 (a+b). They load the flags as if set-flags were 1, leave `rd_we` low in the following cycle, and leave `result` unchanged.
- R6: For a non-test code with `set_flags`=0, `flags` is unchanged.
- R7: On every flag load, `flags[3]` (N) is bit 31 of the computed value and `flags[2]` (Z) is 1 exactly when the computed value is zero.
- R8: For arithmetic and compare codes, `flags[1]` (C) is the unsigned carry out of the addition, which means NOT borrow for subtractions. `flags[0]` (V) is signed overflow.
- R9: For logical and test codes, C takes bit 31 of the rotated constant when `imm_sel`=1 and the rotate field is nonzero. Otherwise C is held. V is always held.
- R10: A cycle with `op_valid`=0 leaves `rd_we` low in the following cycle and keeps `result` and `flags` unchanged.
- R11: An accepted non-test operation raises `rd_we` and presents its value on `result` in the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Load the flag register from this operation |
| imm_sel | input | 1 | Second operand comes from the rotated constant |
| opa | input | 32 | First operand |
| opb_reg | input | 32 | Register value for the second operand |
| imm_field | input | 12 | Rotate count [11:8] and 8-bit constant [7:0] |
| result | output | 32 | Registered result |
| rd_we | output | 1 | Registered destination write-enable |
| flags | output | 4 | Flag register {N, Z, C, V} |

## Verification
Two functions can meet in a single clock edge. A carry-chained operation may consume the held carry while it also loads a new carry into the same register. Likewise, a logical operation with a rotated constant may replace C while keeping V. The bench provokes both with long random streams where about half the operations set flags and the carry-chained codes follow one another directly. It adds directed pairs such as an add that carries out followed by an add with carry. Each edge is judged against a flag model held in the bench, which advances only on the loads the requirements allow.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/fa_operand.sv
module fa_operand #(
  parameter int DATA_W = 32,
  parameter int ROT_W  = 4,
  parameter int IMM_W  = 8
) (
  input  logic                   imm_sel,
  input  logic [DATA_W-1:0]      reg_val,
  input  logic [ROT_W+IMM_W-1:0] imm_field,
  output logic [DATA_W-1:0]      opb,
  output logic                   shc_valid,
  output logic                   shc
);
  localparam int PAD_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] ror(input logic [DATA_W-1:0] v,
                                            input int unsigned amt);
    ror = (v >> amt) | (v << ((DATA_W - amt) % DATA_W));
  endfunction

  logic [ROT_W-1:0]  rot_cnt;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] imm_rot;

  assign rot_cnt   = imm_field[ROT_W+IMM_W-1:IMM_W];
  assign imm_ext   = {{PAD_W{1'b0}}, imm_field[IMM_W-1:0]};
  assign imm_rot   = ror(imm_ext, 2 * int'(rot_cnt));
  assign opb       = imm_sel ? imm_rot : reg_val;
  assign shc_valid = imm_sel && (rot_cnt != '0);
  assign shc       = imm_rot[DATA_W-1];
endmodule

// File: rtl/fa_core.sv
module fa_core
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              c_in,
  input  logic              v_in,
  input  logic              shc_valid,
  input  logic              shc,
  output logic [DATA_W-1:0] res,
  output logic              writes,
  output nzcv_t             flags_out
);
  localparam int MSB = DATA_W - 1;

  // returns {carry, overflow, sum}
  function automatic logic [DATA_W+1:0] add_cv(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic ci);
    logic [DATA_W:0] s;
    logic ov;
    s  = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
    ov = (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]);
    return {s[DATA_W], ov, s[DATA_W-1:0]};
  endfunction

  logic [DATA_W-1:0] add_x, add_y, add_sum;
  logic              add_ci, add_co, add_ov, is_arith;

  always_comb begin
    is_arith = 1'b1;
    add_x    = a;
    add_y    = b;
    add_ci   = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin add_y = ~b; add_ci = 1'b1; end
      OP_RSB:         begin add_x = b; add_y = ~a; add_ci = 1'b1; end
      OP_ADD, OP_CMN: add_ci = 1'b0;
      OP_ADC:         add_ci = c_in;
      OP_SBC:         begin add_y = ~b; add_ci = c_in; end
      OP_RSC:         begin add_x = b; add_y = ~a; add_ci = c_in; end
      default:        is_arith = 1'b0;
    endcase
  end

  assign {add_co, add_ov, add_sum} = add_cv(add_x, add_y, add_ci);

  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = add_sum;
    endcase
  end

  assign writes      = (op[3:2] != 2'b10);
  assign flags_out.n = res[MSB];
  assign flags_out.z = (res == '0);
  assign flags_out.c = is_arith ? add_co : (shc_valid ? shc : c_in);
  assign flags_out.v = is_arith ? add_ov : v_in;
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ROT_W  = 4,
  parameter int IMM_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [3:0]             opcode,
  input  logic                   set_flags,
  input  logic                   imm_sel,
  input  logic [DATA_W-1:0]      opa,
  input  logic [DATA_W-1:0]      opb_reg,
  input  logic [ROT_W+IMM_W-1:0] imm_field,
  output logic [DATA_W-1:0]      result,
  output logic                   rd_we,
  output logic [3:0]             flags
);
  logic [DATA_W-1:0] opb;
  logic              shc_valid, shc;
  logic [DATA_W-1:0] alu_res;
  logic              alu_writes;
  nzcv_t             alu_flags;
  nzcv_t             flags_q;
  logic [DATA_W-1:0] result_q;
  logic              rd_we_q;

  // named events for the checker
  logic flag_load, reg_load;

  fa_operand #(.DATA_W(DATA_W), .ROT_W(ROT_W), .IMM_W(IMM_W)) u_opnd (
    .imm_sel   (imm_sel),
    .reg_val   (opb_reg),
    .imm_field (imm_field),
    .opb       (opb),
    .shc_valid (shc_valid),
    .shc       (shc)
  );

  fa_core #(.DATA_W(DATA_W)) u_core (
    .op        (alu_op_e'(opcode)),
    .a         (opa),
    .b         (opb),
    .c_in      (flags_q.c),
    .v_in      (flags_q.v),
    .shc_valid (shc_valid),
    .shc       (shc),
    .res       (alu_res),
    .writes    (alu_writes),
    .flags_out (alu_flags)
  );

  assign reg_load  = op_valid && alu_writes;
  assign flag_load = op_valid && (set_flags || !alu_writes);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      rd_we_q  <= 1'b0;
      flags_q  <= '0;
    end else begin
      rd_we_q <= reg_load;
      if (reg_load)  result_q <= alu_res;
      if (flag_load) flags_q  <= alu_flags;
    end
  end

  assign result = result_q;
  assign rd_we  = rd_we_q;
  assign flags  = flags_q;
endmodule

// File: rtl/fa_chk.sv
module fa_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        opcode,
  input logic              set_flags,
  input logic [DATA_W-1:0] result,
  input logic              rd_we,
  input logic [3:0]        flags
);
  logic is_test, is_arith;
  assign is_test  = (opcode[3:2] == 2'b10);
  assign is_arith = (opcode inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB});

  // R5
  test_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_test) |=> (!rd_we && $stable(result)));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !set_flags && !is_test) |=> $stable(flags));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!rd_we && $stable(result) && $stable(flags)));

  // R7
  nz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && set_flags && !is_test) |=> (flags[3] == result[DATA_W-1] && flags[2] == (result == '0)));

  // R9
  logic_v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !is_arith) |=> (flags[0] == $past(flags[0])));

  // R11
  write_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !is_test) |=> rd_we);
endmodule

bind flag_alu fa_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .opcode    (opcode),
  .set_flags (set_flags),
  .result    (result),
  .rd_we     (rd_we),
  .flags     (flags)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  opcode;
  logic        set_flags;
  logic        imm_sel;
  logic [31:0] opa;
  logic [31:0] opb_reg;
  logic [11:0] imm_field;
  logic [31:0] result;
  logic        rd_we;
  logic [3:0]  flags;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model state
  logic [31:0] m_res;
  logic [3:0]  m_flags;

  always #2 clk = ~clk;

  flag_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .set_flags(set_flags), .imm_sel(imm_sel), .opa(opa), .opb_reg(opb_reg),
    .imm_field(imm_field), .result(result), .rd_we(rd_we), .flags(flags)
  );

  function automatic logic [31:0] rot_right(input logic [31:0] v, input int n);
    logic [31:0] t = v;
    for (int k = 0; k < n; k++) t = {t[0], t[31:1]};
    return t;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] op, input logic s,
                       input logic isel, input logic [31:0] a,
                       input logic [31:0] rb, input logic [11:0] imm);
    logic [31:0] b, r;
    logic        we, ld, arith, nc, nv;
    longint      ua, ub, us, sa, sb, ss;
    int          ci;
    string       rtag;
    @(negedge clk);
    op_valid = v; opcode = op; set_flags = s; imm_sel = isel;
    opa = a; opb_reg = rb; imm_field = imm;
    // R2: operand selection
    b  = isel ? rot_right({24'd0, imm[7:0]}, 2 * int'(imm[11:8])) : rb;
    ci = int'(m_flags[1]);
    ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
    sa = longint'($signed(a)); sb = longint'($signed(b));
    arith = 1'b1; us = 0; ss = 0;
    case (op)
      4'h2, 4'hA: begin us = ua - ub;        ss = sa - sb; end
      4'h3:       begin us = ub - ua;        ss = sb - sa; end
      4'h4, 4'hB: begin us = ua + ub;        ss = sa + sb; end
      4'h5:       begin us = ua + ub + ci;   ss = sa + sb + ci; end
      4'h6:       begin us = ua - ub - 1 + ci; ss = sa - sb - 1 + ci; end
      4'h7:       begin us = ub - ua - 1 + ci; ss = sb - sa - 1 + ci; end
      default:    arith = 1'b0;
    endcase
    case (op)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC:       r = a | b;
      4'hD:       r = b;
      4'hE:       r = a & ~b;
      4'hF:       r = ~b;
      default:    r = us[31:0];
    endcase
    if (arith) begin
      if (op inside {4'h2, 4'h3, 4'h6, 4'h7, 4'hA}) nc = (us >= 0);
      else nc = (us > 64'sh0_FFFF_FFFF);
      nv = (ss > 64'sh7FFF_FFFF) || (ss < -64'sh8000_0000);
    end else begin
      nc = (isel && imm[11:8] != 0) ? b[31] : m_flags[1];
      nv = m_flags[0];
    end
    we = v && (op[3:2] != 2'b10);
    ld = v && (s || op[3:2] == 2'b10);
    @(posedge clk); #1;
    if (!v) rtag = "R10"; else if (op[3:2] == 2'b10) rtag = "R5";
    else rtag = "R11";
    check(rtag, {31'd0, rd_we}, {31'd0, we});
    if (we) begin
      m_res = r;
      rtag = isel ? "R2" : (arith ? "R3" : "R4");
    end
    check(rtag, result, m_res);
    if (ld) begin
      m_flags = {r[31], r == 32'd0, nc, nv};
      rtag = arith ? "R8" : "R9";
    end else rtag = v ? "R6" : "R10";
    check(rtag, {28'd0, flags}, {28'd0, m_flags});
    if (ld) check("R7", {30'd0, flags[3:2]}, {30'd0, r[31], r == 32'd0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; op_valid = 0; opcode = 0; set_flags = 0; imm_sel = 0;
    opa = 0; opb_reg = 0; imm_field = 0;
    repeat (3) @(posedge clk); #1;
    // R1 during reset
    check("R1", result, 32'd0);
    check("R1", {28'd0, flags, 1'b0, rd_we} >> 1, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {27'd0, flags, rd_we}, 32'd0);
    m_res = 32'd0; m_flags = 4'd0;

    // R2: 0xFF rotated right by 2 -> C000003F, C from bit 31
    apply(1, 4'hD, 1, 1, 32'd0, 32'd0, 12'h1FF);
    check("R2", result, 32'hC000_003F);
    // R9: rotate field zero keeps C
    apply(1, 4'hD, 1, 1, 32'd0, 32'd0, 12'h080);
    // R3/R8: borrow and no-borrow subtract
    apply(1, 4'h2, 1, 0, 32'd0, 32'd1, 12'd0);
    apply(1, 4'h2, 1, 0, 32'd5, 32'd3, 12'd0);
    // R8: signed overflow
    apply(1, 4'h4, 1, 0, 32'h7FFF_FFFF, 32'd1, 12'd0);
    // carry chain: carry out then add with carry
    apply(1, 4'h4, 1, 0, 32'hFFFF_FFFF, 32'd1, 12'd0);
    apply(1, 4'h5, 1, 0, 32'd10, 32'd20, 12'd0);
    apply(1, 4'h7, 1, 0, 32'd3, 32'd9, 12'd0);
    apply(1, 4'h6, 0, 0, 32'd3, 32'd9, 12'd0);
    // R5: compares
    apply(1, 4'hA, 0, 0, 32'd7, 32'd7, 12'd0);
    apply(1, 4'hB, 0, 1, 32'hFFFF_FF00, 32'd0, 12'h4FF);
    apply(1, 4'h8, 0, 0, 32'hF0F0_0000, 32'h0F0F_FFFF, 12'd0);
    // R10: idle
    apply(0, 4'h4, 1, 0, 32'd1, 32'd1, 12'd0);
    // R4: logical set
    apply(1, 4'hE, 1, 0, 32'hFFFF_FFFF, 32'h0000_FFFF, 12'd0);
    apply(1, 4'hF, 1, 0, 32'd0, 32'hFFFF_FFFF, 12'd0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if ((i % 7) == 0) ra = {$urandom_range(1, 0) == 1 ? 1'b1 : 1'b0, 31'd0};
      if ((i % 11) == 0) rb = 32'hFFFF_FFFF;
      apply(($urandom % 8) != 0, 4'($urandom), 1'($urandom), 1'($urandom),
            ra, rb, 12'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule